// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes an opcode byte and two operands, `opnd_a` and `opnd_b`. It produces the value that the accumulator should take, a write strobe for the accumulator, and the next state of four condition flags. The result path is purely combinational. The flags live in a register inside the block, which loads the next flag value on every clock edge.

Each operation names the flags it defines. A flag that an operation does not define keeps its stored value, so chained operations work. For example, a logic mask can follow an add without losing the add's carry. The carry used by add-with-carry and by the two rotates is the stored carry flag. An opcode the block does not know leaves the accumulator and the flags alone, so NOP and non-ALU opcodes can be driven into it freely.

Top module: `acc_alu`

## Requirements
- R1: The flag word is packed {neg, carry, ovfl, zero} in bits 3 down to 0 of `flags_q` and `flags_next`. A synchronous active-high `rst` clears `flags_q` to 0.
- R2: On each rising clock edge without reset, `flags_q` takes the value that `flags_next` showed in that cycle.
- R3: ADD (0x01) gives the low 8 bits of a+b. Carry is the carry-out of that 8-bit sum. Ovfl is set when a and b have equal sign bits and the result's sign bit differs from them. All four flags are updated.
- R4: ADDC (0x05) behaves as ADD, with the stored carry flag added in as well.
- R5: SUB (0x09) forms the 8-bit two's complement of b, then adds it to a. Result and all four flags follow R3 applied to a and that complement. For b = 0 the complement is 0, so carry is 0.
- R6: AND (0x11), OR (0x15) and XOR (0x19) combine a and b bit by bit. NOT (0x1D) inverts a. These update only neg and zero.
- R7: LAND (0x0D) gives 0xFF when both a and b are non-zero. LOR (0x35) gives 0xFF when either is non-zero. LNOT (0x3D) gives 0xFF when a is zero. Otherwise each gives 0x00. They update only neg and zero.
- R8: SHL (0x21) shifts a left with a 0 fill, and carry takes the old a[7]. SHR (0x25) shifts a right with a 0 fill, carry takes the old a[0], and neg is always cleared. Ovfl is kept by both.
- R9: ROTL (0x29) shifts a left with the stored carry entering bit 0, and carry takes the old a[7]. ROTR (0x2D) shifts a right with the stored carry entering bit 7, and carry takes the old a[0]. Ovfl is kept by both.
- R10: COMP (0x39) gives the two's complement of b and clears carry and ovfl.
- R11: For every recognized opcode, `acc_we` is 1 and zero is set exactly when the result is 0. Neg equals result bit 7 for every recognized opcode except SHR.
- R12: Any other opcode drives `acc_we` to 0 and leaves all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| opcode | input | 8 | Operation code |
| opnd_a | input | 8 | First operand (only operand for NOT, LNOT, shifts and rotates) |
| opnd_b | input | 8 | Second operand (only operand for COMP) |
| result | output | 8 | Value for the accumulator |
| acc_we | output | 1 | Accumulator write strobe, high for recognized opcodes |
| flags_next | output | 4 | Flag value after this operation, {neg, carry, ovfl, zero} |
| flags_q | output | 4 | Stored flags, {neg, carry, ovfl, zero} |

## Verification
The checker watches the rules that hold on every cycle. These are the register loading its next value and clearing on reset, and unknown opcodes freezing the flags. They also include the zero and neg flags tracking the result, carry and ovfl being kept by the bit-wise and truth-value operations, SHR never raising neg, and COMP clearing carry and ovfl. Only the bench's scenarios can show that the arithmetic values are correct. This covers the overflow and carry-out cases at the sign boundary, carry flowing from one operation into a following ADDC or rotate, and the two's-complement edges of SUB and COMP.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int FLAG_W = 4;

    typedef enum logic [7:0] {
        OPC_ADD  = 8'h01,
        OPC_ADDC = 8'h05,
        OPC_SUB  = 8'h09,
        OPC_LAND = 8'h0D,
        OPC_AND  = 8'h11,
        OPC_OR   = 8'h15,
        OPC_XOR  = 8'h19,
        OPC_NOT  = 8'h1D,
        OPC_SHL  = 8'h21,
        OPC_SHR  = 8'h25,
        OPC_ROTL = 8'h29,
        OPC_ROTR = 8'h2D,
        OPC_LOR  = 8'h35,
        OPC_COMP = 8'h39,
        OPC_LNOT = 8'h3D
    } opc_e;

    typedef enum logic [3:0] {
        K_ADD, K_ADDC, K_SUB, K_AND, K_OR, K_XOR, K_NOT, K_LAND,
        K_LOR, K_LNOT, K_SHL, K_SHR, K_ROTL, K_ROTR, K_COMP, K_NONE
    } kind_e;

    typedef struct packed {
        logic neg;
        logic carry;
        logic ovfl;
        logic zero;
    } flags_t;

    typedef struct packed {
        kind_e  kind;
        logic   valid;
        flags_t upd;
    } dec_t;

    localparam flags_t UPD_ALL   = '{neg: 1'b1, carry: 1'b1, ovfl: 1'b1, zero: 1'b1};
    localparam flags_t UPD_NZ    = '{neg: 1'b1, carry: 1'b0, ovfl: 1'b0, zero: 1'b1};
    localparam flags_t UPD_NCZ   = '{neg: 1'b1, carry: 1'b1, ovfl: 1'b0, zero: 1'b1};
    localparam flags_t UPD_NONE  = '{neg: 1'b0, carry: 1'b0, ovfl: 1'b0, zero: 1'b0};

    // Signed overflow of an addition from the three sign bits.
    function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
        return (sa == sb) && (sr != sa);
    endfunction

    // Keep masked-out bits of the old flags, take masked-in bits of the new.
    function automatic flags_t merge_flags(input flags_t old_f, input flags_t new_f,
                                           input flags_t mask);
        return flags_t'((old_f & ~mask) | (new_f & mask));
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import acc_alu_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);

    always_comb begin
        dec = '{kind: K_NONE, valid: 1'b0, upd: UPD_NONE};
        case (opcode)
            OPC_ADD:  dec = '{kind: K_ADD,  valid: 1'b1, upd: UPD_ALL};
            OPC_ADDC: dec = '{kind: K_ADDC, valid: 1'b1, upd: UPD_ALL};
            OPC_SUB:  dec = '{kind: K_SUB,  valid: 1'b1, upd: UPD_ALL};
            OPC_COMP: dec = '{kind: K_COMP, valid: 1'b1, upd: UPD_ALL};
            OPC_AND:  dec = '{kind: K_AND,  valid: 1'b1, upd: UPD_NZ};
            OPC_OR:   dec = '{kind: K_OR,   valid: 1'b1, upd: UPD_NZ};
            OPC_XOR:  dec = '{kind: K_XOR,  valid: 1'b1, upd: UPD_NZ};
            OPC_NOT:  dec = '{kind: K_NOT,  valid: 1'b1, upd: UPD_NZ};
            OPC_LAND: dec = '{kind: K_LAND, valid: 1'b1, upd: UPD_NZ};
            OPC_LOR:  dec = '{kind: K_LOR,  valid: 1'b1, upd: UPD_NZ};
            OPC_LNOT: dec = '{kind: K_LNOT, valid: 1'b1, upd: UPD_NZ};
            OPC_SHL:  dec = '{kind: K_SHL,  valid: 1'b1, upd: UPD_NCZ};
            OPC_SHR:  dec = '{kind: K_SHR,  valid: 1'b1, upd: UPD_NCZ};
            OPC_ROTL: dec = '{kind: K_ROTL, valid: 1'b1, upd: UPD_NCZ};
            OPC_ROTR: dec = '{kind: K_ROTR, valid: 1'b1, upd: UPD_NCZ};
            default:  dec = '{kind: K_NONE, valid: 1'b0, upd: UPD_NONE};
        endcase
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  kind_e        kind,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output flags_t       raw
);

    localparam int SW = W + 1;
    localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TRUEV = '1;

    logic [W-1:0]  neg_b;      // two's complement of b
    logic [W-1:0]  add_b;      // second adder input
    logic          add_cin;
    logic [SW-1:0] sum;
    logic          a_set, b_set;

    // One shared adder serves ADD, ADDC and SUB.
    always_comb begin
        neg_b   = ~b + ONE;
        add_b   = (kind == K_SUB) ? neg_b : b;
        add_cin = (kind == K_ADDC) ? cin : 1'b0;
        sum     = {1'b0, a} + {1'b0, add_b} + {{W{1'b0}}, add_cin};
        a_set   = |a;
        b_set   = |b;
    end

    always_comb begin
        res       = '0;
        raw.carry = 1'b0;
        raw.ovfl  = 1'b0;
        case (kind)
            K_ADD, K_ADDC, K_SUB: begin
                res       = sum[W-1:0];
                raw.carry = sum[W];
                raw.ovfl  = add_ovf(a[W-1], add_b[W-1], sum[W-1]);
            end
            K_COMP: res = neg_b;
            K_AND:  res = a & b;
            K_OR:   res = a | b;
            K_XOR:  res = a ^ b;
            K_NOT:  res = ~a;
            K_LAND: res = (a_set && b_set) ? TRUEV : '0;
            K_LOR:  res = (a_set || b_set) ? TRUEV : '0;
            K_LNOT: res = a_set ? '0 : TRUEV;
            K_SHL: begin
                res       = {a[W-2:0], 1'b0};
                raw.carry = a[W-1];
            end
            K_SHR: begin
                res       = {1'b0, a[W-1:1]};
                raw.carry = a[0];
            end
            K_ROTL: begin
                res       = {a[W-2:0], cin};
                raw.carry = a[W-1];
            end
            K_ROTR: begin
                res       = {cin, a[W-1:1]};
                raw.carry = a[0];
            end
            default: res = '0;
        endcase
        raw.neg  = (kind == K_SHR) ? 1'b0 : res[W-1];
        raw.zero = ~|res;
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import acc_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t raw,
    input  flags_t upd,
    output flags_t nxt,
    output flags_t q
);

    always_comb nxt = merge_flags(q, raw, upd);

    always_ff @(posedge clk) begin
        if (rst) q <= UPD_NONE;
        else     q <= nxt;
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        opcode,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    output logic [W-1:0]      result,
    output logic              acc_we,
    output logic [FLAG_W-1:0] flags_next,
    output logic [FLAG_W-1:0] flags_q
);

    dec_t   dec;
    flags_t raw_f, nxt_f, cur_f;

    alu_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    alu_core #(.W(W)) u_core (
        .kind (dec.kind),
        .a    (opnd_a),
        .b    (opnd_b),
        .cin  (cur_f.carry),
        .res  (result),
        .raw  (raw_f)
    );

    alu_flag_reg u_flags (
        .clk (clk),
        .rst (rst),
        .raw (raw_f),
        .upd (dec.upd),
        .nxt (nxt_f),
        .q   (cur_f)
    );

    assign acc_we     = dec.valid;
    assign flags_next = nxt_f;
    assign flags_q    = cur_f;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        opcode,
    input logic [W-1:0]      result,
    input logic              acc_we,
    input logic [FLAG_W-1:0] flags_next,
    input logic [FLAG_W-1:0] flags_q
);

    logic is_bitlogic;
    assign is_bitlogic = (opcode == OPC_AND) || (opcode == OPC_OR) || (opcode == OPC_XOR) ||
                         (opcode == OPC_NOT) || (opcode == OPC_LAND) ||
                         (opcode == OPC_LOR) || (opcode == OPC_LNOT);

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> flags_q == '0);

    p_load_next_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> flags_q == $past(flags_next));

    p_keep_cv_r6: assert property (@(posedge clk) disable iff (rst)
        is_bitlogic |-> flags_next[2:1] == flags_q[2:1]);

    p_truth_value_r7: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_LAND || opcode == OPC_LOR || opcode == OPC_LNOT) |->
        (result == '0 || result == '1));

    p_shr_neg_low_r8: assert property (@(posedge clk) disable iff (rst)
        opcode == OPC_SHR |-> !flags_next[3]);

    p_comp_clear_r10: assert property (@(posedge clk) disable iff (rst)
        opcode == OPC_COMP |-> flags_next[2:1] == 2'b00);

    p_zero_tracks_r11: assert property (@(posedge clk) disable iff (rst)
        acc_we |-> flags_next[0] == (result == '0));

    p_neg_tracks_r11: assert property (@(posedge clk) disable iff (rst)
        (acc_we && opcode != OPC_SHR) |-> flags_next[3] == result[W-1]);

    p_unknown_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !acc_we |=> flags_q == $past(flags_q));

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .result     (result),
    .acc_we     (acc_we),
    .flags_next (flags_next),
    .flags_q    (flags_q)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opcode = 8'h00;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic [7:0] result;
    logic       acc_we;
    logic [3:0] flags_next;
    logic [3:0] flags_q;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    acc_alu i_acc_alu (
        .clk        (clk),
        .rst        (rst),
        .opcode     (opcode),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .result     (result),
        .acc_we     (acc_we),
        .flags_next (flags_next),
        .flags_q    (flags_q)
    );

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] res;
        logic       we;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'h7F, 8'h01, 8'h80, 1'b1},  // ADD signed overflow
        '{8'h01, 8'hFF, 8'h01, 8'h00, 1'b1},  // ADD carry-out, zero
        '{8'h05, 8'h10, 8'h20, 8'h31, 1'b1},  // ADDC with carry 1
        '{8'h09, 8'h05, 8'h03, 8'h02, 1'b1},  // SUB positive
        '{8'h09, 8'h03, 8'h05, 8'hFE, 1'b1},  // SUB negative
        '{8'h09, 8'h80, 8'h01, 8'h7F, 1'b1},  // SUB overflow
        '{8'h11, 8'hF0, 8'h3C, 8'h30, 1'b1},  // AND
        '{8'h15, 8'h80, 8'h01, 8'h81, 1'b1},  // OR
        '{8'h19, 8'hAA, 8'hAA, 8'h00, 1'b1},  // XOR
        '{8'h1D, 8'hFF, 8'h00, 8'h00, 1'b1},  // NOT
        '{8'h0D, 8'h04, 8'h00, 8'h00, 1'b1},  // LAND false
        '{8'h0D, 8'h04, 8'h80, 8'hFF, 1'b1},  // LAND true
        '{8'h35, 8'h00, 8'h00, 8'h00, 1'b1},  // LOR false
        '{8'h3D, 8'h00, 8'h00, 8'hFF, 1'b1},  // LNOT true
        '{8'h21, 8'h81, 8'h00, 8'h02, 1'b1},  // SHL
        '{8'h25, 8'h01, 8'h00, 8'h00, 1'b1},  // SHR
        '{8'h29, 8'h40, 8'h00, 8'h81, 1'b1},  // ROTL carry 1 in
        '{8'h2D, 8'h01, 8'h00, 8'h00, 1'b1},  // ROTR carry 0 in
        '{8'h2D, 8'h02, 8'h00, 8'h81, 1'b1},  // ROTR carry 1 in
        '{8'h39, 8'h00, 8'h01, 8'hFF, 1'b1},  // COMP
        '{8'h39, 8'h00, 8'h00, 8'h00, 1'b1},  // COMP zero
        '{8'h00, 8'h12, 8'h34, 8'h00, 1'b0},  // unrecognized
        '{8'h04, 8'h12, 8'h34, 8'h00, 1'b0},  // unrecognized
        '{8'h05, 8'hFF, 8'h00, 8'hFF, 1'b1}   // ADDC with carry 0
    };

    function automatic string req_of(input logic [7:0] op);
        case (op)
            8'h01: return "R3";
            8'h05: return "R4";
            8'h09: return "R5";
            8'h11, 8'h15, 8'h19, 8'h1D: return "R6";
            8'h0D, 8'h35, 8'h3D: return "R7";
            8'h21, 8'h25: return "R8";
            8'h29, 8'h2D: return "R9";
            8'h39: return "R10";
            default: return "R12";
        endcase
    endfunction

    // Expected flags {neg, carry, ovfl, zero} from the requirements.
    function automatic logic [3:0] model(input logic [7:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic [7:0] r,
                                         input logic [3:0] cur);
        logic [3:0] f = cur;
        int ia = int'(a);
        int ib = int'(b);
        int s;
        case (op)
            8'h01, 8'h05, 8'h09: begin
                if (op == 8'h09) ib = (256 - ib) % 256;
                s = ia + ib + ((op == 8'h05) ? int'(cur[2]) : 0);
                f[2] = (s > 255);
                f[1] = ((ia >= 128) == (ib >= 128)) && ((r >= 128) != (ia >= 128));
            end
            8'h39: f[2:1] = 2'b00;
            8'h21, 8'h29: f[2] = a[7];
            8'h25, 8'h2D: f[2] = a[0];
            default: ;
        endcase
        if (op inside {8'h01, 8'h05, 8'h09, 8'h39, 8'h11, 8'h15, 8'h19, 8'h1D, 8'h0D,
                       8'h35, 8'h3D, 8'h21, 8'h25, 8'h29, 8'h2D}) begin
            f[3] = (op == 8'h25) ? 1'b0 : r[7];
            f[0] = (r == 8'h00);
        end
        return f;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        opcode = op;
        opnd_a = a;
        opnd_b = b;
        #5;
    endtask

    initial begin
        logic [3:0] mflags;
        // reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset flags", {4'h0, flags_q}, 8'h00);
        rst = 1'b0;
        mflags = 4'h0;

        for (int i = 0; i < NV; i++) begin
            logic [3:0] exp_f;
            string tg;
            tg = req_of(VECS[i].op);
            apply(VECS[i].op, VECS[i].a, VECS[i].b);
            exp_f = model(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].res, mflags);
            check({tg, " R11 we"}, {7'h0, acc_we}, {7'h0, VECS[i].we});
            if (VECS[i].we) check({tg, " result"}, result, VECS[i].res);
            check({tg, " R11 flags_next"}, {4'h0, flags_next}, {4'h0, exp_f});
            @(posedge clk);
            #1;
            check({tg, " R2 flags_q"}, {4'h0, flags_q}, {4'h0, exp_f});
            mflags = exp_f;
        end

        // carry chain: ADD sets carry, ADDC consumes it (R4)
        apply(8'h01, 8'hFF, 8'h01);
        @(posedge clk);
        apply(8'h05, 8'hFF, 8'h00);
        check("R4 chained result", result, 8'h00);
        check("R4 chained flags", {4'h0, flags_next}, 8'h05);

        // SUB with b = 0 gives carry 0 (R5)
        apply(8'h09, 8'h42, 8'h00);
        check("R5 sub zero result", result, 8'h42);
        check("R5 sub zero flags", {4'h0, flags_next}, 8'h00);

        // unknown opcode held for several cycles keeps flags (R12)
        apply(8'h81, 8'h01, 8'h01);   // flags_q becomes 0 from previous SUB
        @(posedge clk);
        apply(8'h01, 8'h80, 8'h80);   // sets carry, ovfl, zero: 0111
        @(posedge clk);
        apply(8'hFF, 8'h00, 8'h00);
        repeat (3) @(posedge clk);
        #1;
        check("R12 hold flags_q", {4'h0, flags_q}, 8'h07);

        // mid-run reset clears flags (R1)
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", {4'h0, flags_q}, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule